// File: doc/BRIEF.md
# Floating-Point Escape 0xDC Instruction Decoder

This block takes an instruction byte stream, one byte per cycle over a valid/ready handshake. It decodes instructions that start with the floating-point escape opcode 0xDC. After the opcode it reads the ModRM byte and splits it into three fields. In this instruction group the middle field names the arithmetic operation, not a register. The top two bits choose between a stack-register operand and a memory operand. When the operand is in memory, the same two bits tell the block how many displacement bytes to collect before the decode is finished.

When the instruction is complete, the block holds one decoded record on a valid/ready output until the record is taken. The record holds:
- the operation code
- a memory/register flag
- a flag saying whether a base register is used
- the register index
- the displacement, sign-extended to 32 bits
- the operand width in bytes
- the instruction length

Only 32-bit addressing is handled. An opcode other than 0xDC, or a form that would need a scale-index byte, produces a record with the error flag set.

Top module: `fpu_esc_decoder`

## Requirements
- R1: While synchronous reset is high, and in the cycle after it falls, `outValid` is 0 and `inReady` is 1, so the block is waiting for an opcode byte.
- R2: A byte is taken only on a cycle where `inValid` and `inReady` are both 1. While a record is held, `inReady` is 0. The record is stable until a cycle where `outValid` and `outReady` are both 1, and the block then returns to waiting for an opcode.
- R3: If the first byte is not 0xDC, the block emits a record with `outErr`=1 and `outLen`=1.
- R4: In the ModRM byte, bits 7:6 are mod, bits 5:3 are reg and bits 2:0 are r/m. `outOp` equals reg, with this meaning: 0 add, 1 mul, 2 com, 3 comp, 4 sub, 5 subr, 6 div, 7 divr.
- R5: When mod=3 (ModRM 0xC0 to 0xFF), the operand is a register. The record has `outIsMem`=0, `outHasBase`=0, `outRegIdx` = r/m (the stack slot), `outDisp`=0, `outOpBytes`=10 and `outLen`=2.
- R6: Every memory form without an error reports `outIsMem`=1 and `outOpBytes`=8, whatever the address width.
- R7: When mod=2, four displacement bytes follow, least significant first. The record has `outHasBase`=1, `outRegIdx` = r/m and `outLen`=6. For example, DC 82 04 08 0D 00 gives op 0, memory, base 2, displacement 0x000D0804, length 6.
- R8: When mod=1, one displacement byte follows. It is sign-extended to 32 bits, and `outLen`=3.
- R9: When mod=0 and r/m is neither 4 nor 5, no displacement follows. The record has `outDisp`=0, `outHasBase`=1, `outRegIdx` = r/m and `outLen`=2.
- R10: When mod=0 and r/m=5, the address is absolute. Four displacement bytes follow, and the record has `outHasBase`=0 and `outLen`=6.
- R11: When r/m=4 and mod is not 3, the block emits an error record with `outLen`=2 right after the ModRM byte. It takes no further bytes for that instruction.
- R12: The record's `outValid` rises on the cycle right after the clock edge that takes the last byte of the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inByte | input | 8 | Instruction byte |
| inValid | input | 1 | inByte is valid |
| inReady | output | 1 | Block can take a byte |
| outValid | output | 1 | Decoded record is valid |
| outReady | input | 1 | Consumer takes the record |
| outOp | output | 3 | Operation (reg field) |
| outIsMem | output | 1 | 1 for a memory operand |
| outHasBase | output | 1 | A base register is used |
| outRegIdx | output | 3 | Base register or stack slot (r/m) |
| outDisp | output | 32 | Sign-extended displacement |
| outOpBytes | output | 4 | Operand width in bytes (8 or 10) |
| outLen | output | 4 | Instruction length in bytes |
| outErr | output | 1 | Unsupported form |

## Verification
The stream includes register forms that sweep all eight reg values. This shows that the operation is taken from the middle field and the stack index from the low field. Memory forms cover every mod value. Among them are a one-byte displacement of 0x7F and one of 0x80, which separate sign extension from zero extension. There are also the multi-byte example and the absolute r/m=5 case, which check byte order and the length of the gather. Bad opcodes and each scale-index form are interleaved with good instructions under consumer stalls. This shows that an error leaves no stale field behind and that the handshake drops no record.

// File: rtl/fpu_esc_pkg.sv
package fpu_esc_pkg;
  typedef enum logic [2:0] {
    OP_ADD, OP_MUL, OP_COM, OP_COMP, OP_SUB, OP_SUBR, OP_DIV, OP_DIVR
  } fpOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic start;      // opcode byte taken
    logic takeModrm;  // ModRM byte taken
    logic takeDisp;   // displacement byte taken
    logic flagErr;    // mark record as unsupported
  } ctrlStrobe_t;

  typedef enum logic [1:0] {S_OPC, S_MODRM, S_DISP, S_HOLD} decState_e;
endpackage

// File: rtl/fpu_esc_datapath.sv
module fpu_esc_datapath #(
  parameter int BYTE_W    = 8,
  parameter int DISP_BYTES = 4,
  parameter int LEN_W     = 4,
  parameter logic [BYTE_W-1:0] ESC_OPCODE = 8'hDC
) (
  input  logic                        clk,
  input  logic                        rst,
  input  fpu_esc_pkg::ctrlStrobe_t    strobe,
  input  logic [BYTE_W-1:0]           inByte,
  output logic                        isEsc,
  output logic                        sibForm,
  output logic                        noDispNow,
  output logic                        dispLast,
  output logic [2:0]                  outOp,
  output logic                        outIsMem,
  output logic                        outHasBase,
  output logic [2:0]                  outRegIdx,
  output logic [DISP_BYTES*BYTE_W-1:0] outDisp,
  output logic [3:0]                  outOpBytes,
  output logic [LEN_W-1:0]            outLen,
  output logic                        outErr
);
  localparam int DISP_W = DISP_BYTES * BYTE_W;
  localparam int IDX_W  = (DISP_BYTES > 1) ? $clog2(DISP_BYTES) : 1;
  localparam int NEED_W = $clog2(DISP_BYTES + 1);

  logic [1:0]        modReg;
  logic [2:0]        regReg, rmReg;
  logic [DISP_W-1:0] dispReg;
  logic [IDX_W-1:0]  dispIdx;
  logic [NEED_W-1:0] dispNeed, needNow;
  logic [LEN_W-1:0]  lenReg;
  logic              errReg;

  logic [1:0] byteMod;
  logic [2:0] byteRm;
  assign byteMod = inByte[7:6];
  assign byteRm  = inByte[2:0];

  // displacement bytes implied by the incoming ModRM byte
  always_comb begin
    unique case (byteMod)
      2'd0:    needNow = (byteRm == 3'd5) ? NEED_W'(DISP_BYTES) : '0;
      2'd1:    needNow = NEED_W'(1);
      2'd2:    needNow = NEED_W'(DISP_BYTES);
      default: needNow = '0;
    endcase
  end

  assign isEsc     = (inByte == ESC_OPCODE);
  assign sibForm   = (byteMod != 2'd3) && (byteRm == 3'd4);
  assign noDispNow = (needNow == '0);
  assign dispLast  = (NEED_W'(dispIdx) == dispNeed - NEED_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      modReg   <= '0;
      regReg   <= '0;
      rmReg    <= '0;
      dispReg  <= '0;
      dispIdx  <= '0;
      dispNeed <= '0;
      lenReg   <= '0;
      errReg   <= 1'b0;
    end else begin
      if (strobe.start) begin
        modReg   <= '0;
        regReg   <= '0;
        rmReg    <= '0;
        dispReg  <= '0;
        dispIdx  <= '0;
        dispNeed <= '0;
        lenReg   <= LEN_W'(1);
        errReg   <= strobe.flagErr;
      end else if (strobe.flagErr) begin
        errReg <= 1'b1;
      end
      if (strobe.takeModrm) begin
        modReg   <= byteMod;
        regReg   <= inByte[5:3];
        rmReg    <= byteRm;
        dispNeed <= needNow;
        lenReg   <= lenReg + LEN_W'(1);
      end
      if (strobe.takeDisp) begin
        dispReg[dispIdx*BYTE_W +: BYTE_W] <= inByte;
        dispIdx <= dispIdx + IDX_W'(1);
        lenReg  <= lenReg + LEN_W'(1);
      end
    end
  end

  assign outOp      = regReg;
  assign outIsMem   = (modReg != 2'd3);
  assign outHasBase = outIsMem && !((modReg == 2'd0) && (rmReg == 3'd5));
  assign outRegIdx  = rmReg;
  assign outDisp    = (modReg == 2'd1) ? {{(DISP_W-BYTE_W){dispReg[BYTE_W-1]}}, dispReg[BYTE_W-1:0]}
                                       : dispReg;
  assign outOpBytes = outIsMem ? 4'd8 : 4'd10;
  assign outLen     = lenReg;
  assign outErr     = errReg;
endmodule

// File: rtl/fpu_esc_ctrl.sv
module fpu_esc_ctrl (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic                     outReady,
  input  logic                     isEsc,
  input  logic                     sibForm,
  input  logic                     noDispNow,
  input  logic                     dispLast,
  output logic                     inReady,
  output logic                     outValid,
  output fpu_esc_pkg::ctrlStrobe_t strobe
);
  import fpu_esc_pkg::*;

  decState_e state, nextState;
  logic      fire;

  assign inReady  = (state != S_HOLD);
  assign outValid = (state == S_HOLD);
  assign fire     = inValid && inReady;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      S_OPC: if (fire) begin
        strobe.start = 1'b1;
        if (isEsc) nextState = S_MODRM;
        else begin
          strobe.flagErr = 1'b1;
          nextState      = S_HOLD;
        end
      end
      S_MODRM: if (fire) begin
        strobe.takeModrm = 1'b1;
        if (sibForm) begin
          strobe.flagErr = 1'b1;
          nextState      = S_HOLD;
        end else if (noDispNow) nextState = S_HOLD;
        else                    nextState = S_DISP;
      end
      S_DISP: if (fire) begin
        strobe.takeDisp = 1'b1;
        if (dispLast) nextState = S_HOLD;
      end
      default: if (outReady) nextState = S_OPC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_OPC;
    else     state <= nextState;
  end
endmodule

// File: rtl/fpu_esc_decoder.sv
module fpu_esc_decoder #(
  parameter int BYTE_W     = 8,
  parameter int DISP_BYTES = 4,
  parameter int LEN_W      = 4,
  parameter logic [BYTE_W-1:0] ESC_OPCODE = 8'hDC
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [BYTE_W-1:0]            inByte,
  input  logic                         inValid,
  output logic                         inReady,
  output logic                         outValid,
  input  logic                         outReady,
  output logic [2:0]                   outOp,
  output logic                         outIsMem,
  output logic                         outHasBase,
  output logic [2:0]                   outRegIdx,
  output logic [DISP_BYTES*BYTE_W-1:0] outDisp,
  output logic [3:0]                   outOpBytes,
  output logic [LEN_W-1:0]             outLen,
  output logic                         outErr
);
  fpu_esc_pkg::ctrlStrobe_t strobe;
  logic isEsc, sibForm, noDispNow, dispLast;

  fpu_esc_ctrl ctrl_i (
    .clk(clk), .rst(rst), .inValid(inValid), .outReady(outReady),
    .isEsc(isEsc), .sibForm(sibForm), .noDispNow(noDispNow), .dispLast(dispLast),
    .inReady(inReady), .outValid(outValid), .strobe(strobe)
  );

  fpu_esc_datapath #(
    .BYTE_W(BYTE_W), .DISP_BYTES(DISP_BYTES), .LEN_W(LEN_W), .ESC_OPCODE(ESC_OPCODE)
  ) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .inByte(inByte),
    .isEsc(isEsc), .sibForm(sibForm), .noDispNow(noDispNow), .dispLast(dispLast),
    .outOp(outOp), .outIsMem(outIsMem), .outHasBase(outHasBase), .outRegIdx(outRegIdx),
    .outDisp(outDisp), .outOpBytes(outOpBytes), .outLen(outLen), .outErr(outErr)
  );
endmodule

// File: rtl/fpu_esc_checker.sv
module fpu_esc_checker #(
  parameter int BYTE_W     = 8,
  parameter int DISP_BYTES = 4,
  parameter int LEN_W      = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic [BYTE_W-1:0]            inByte,
  input logic                         inValid,
  input logic                         inReady,
  input logic                         outValid,
  input logic                         outReady,
  input logic [2:0]                   outOp,
  input logic                         outIsMem,
  input logic                         outHasBase,
  input logic [2:0]                   outRegIdx,
  input logic [DISP_BYTES*BYTE_W-1:0] outDisp,
  input logic [3:0]                   outOpBytes,
  input logic [LEN_W-1:0]             outLen,
  input logic                         outErr
);
  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && inReady));

  assert_no_intake_while_held_R2: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !inReady);

  assert_record_stable_R2: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outLen) && $stable(outDisp)
                                 && $stable(outOp) && $stable(outErr) && $stable(outRegIdx)));

  assert_reg_form_len_R5: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outErr && !outIsMem) |-> (outLen == LEN_W'(2) && outOpBytes == 4'd10));

  assert_mem_width_R6: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outErr && outIsMem) |-> (outOpBytes == 4'd8));

  assert_err_len_R11: assert property (@(posedge clk) disable iff (rst)
    (outValid && outErr) |-> (outLen <= LEN_W'(2)));
endmodule

bind fpu_esc_decoder fpu_esc_checker #(
  .BYTE_W(BYTE_W), .DISP_BYTES(DISP_BYTES), .LEN_W(LEN_W)
) chk_i (.*);

// File: tb/fpu_esc_decoder_tb_top.sv
module fpu_esc_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [2:0]  op;
    logic        isMem;
    logic        hasBase;
    logic [2:0]  idx;
    logic [31:0] disp;
    logic [3:0]  opBytes;
    logic [3:0]  len;
    logic        err;
    string       tag;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] inByte = '0;
  logic inValid = 1'b0, outReady = 1'b0;
  logic inReady, outValid, outIsMem, outHasBase, outErr;
  logic [2:0] outOp, outRegIdx;
  logic [31:0] outDisp;
  logic [3:0] outOpBytes, outLen;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fpu_esc_decoder dut_i (
    .clk(clk), .rst(rst), .inByte(inByte), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outOp(outOp), .outIsMem(outIsMem),
    .outHasBase(outHasBase), .outRegIdx(outRegIdx), .outDisp(outDisp),
    .outOpBytes(outOpBytes), .outLen(outLen), .outErr(outErr)
  );

  task automatic check(input bit ok, input string what, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", what, act, exp);
    end
  endtask

  // send n bytes held MSB-first in seq; called at a negedge
  task automatic sendSeq(input int n, input logic [47:0] seq, input exp_t e);
    expQ.push_back(e);
    for (int i = 0; i < n; i++) begin
      inByte  = seq[47 - 8*i -: 8];
      inValid = 1'b1;
      while (!inReady) @(negedge clk);
      @(negedge clk);
      inValid = 1'b0;
    end
    // R12: record valid right after the last byte's edge
    check(outValid === 1'b1, {"R12 record timing ", e.tag},
          $sformatf("%b", outValid), "1");
  endtask

  function automatic exp_t mk(input logic [2:0] op, input logic isMem, input logic hasBase,
                              input logic [2:0] idx, input logic [31:0] disp,
                              input logic [3:0] len, input string tag);
    exp_t e;
    e.op = op; e.isMem = isMem; e.hasBase = hasBase; e.idx = idx; e.disp = disp;
    e.opBytes = isMem ? 4'd8 : 4'd10; e.len = len; e.err = 1'b0; e.tag = tag;
    return e;
  endfunction

  function automatic exp_t mkErr(input logic [3:0] len, input string tag);
    exp_t e;
    e = mk(3'd0, 1'b0, 1'b0, 3'd0, 32'd0, len, tag);
    e.err = 1'b1;
    return e;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !finished) begin
      outReady = (cyc % 3) != 0;
      if (outValid) check(inReady === 1'b0, "R2 intake blocked while held",
                          $sformatf("%b", inReady), "0");
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected record", $sformatf("len=%0d", outLen), "none");
        end else begin
          exp_t e;
          string act, expS;
          bit ok;
          e = expQ.pop_front();
          if (e.err) begin
            ok = (outErr === 1'b1) && (outLen === e.len);
            act  = $sformatf("err=%b len=%0d", outErr, outLen);
            expS = $sformatf("err=1 len=%0d", e.len);
          end else begin
            ok = (outErr === 1'b0) && (outOp === e.op) && (outIsMem === e.isMem) &&
                 (outHasBase === e.hasBase) && (outRegIdx === e.idx) && (outDisp === e.disp) &&
                 (outOpBytes === e.opBytes) && (outLen === e.len);
            act  = $sformatf("err=%b op=%0d mem=%b base=%b idx=%0d disp=%h bytes=%0d len=%0d",
                             outErr, outOp, outIsMem, outHasBase, outRegIdx, outDisp, outOpBytes, outLen);
            expS = $sformatf("err=0 op=%0d mem=%b base=%b idx=%0d disp=%h bytes=%0d len=%0d",
                             e.op, e.isMem, e.hasBase, e.idx, e.disp, e.opBytes, e.len);
          end
          check(ok, e.tag, act, expS);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outValid === 1'b0 && inReady === 1'b1, "R1 during reset",
          $sformatf("v=%b r=%b", outValid, inReady), "v=0 r=1");
    rst = 1'b0;
    @(negedge clk);
    check(outValid === 1'b0 && inReady === 1'b1, "R1 after reset",
          $sformatf("v=%b r=%b", outValid, inReady), "v=0 r=1");

    sendSeq(6, 48'hDC_82_04_08_0D_00, mk(3'd0, 1, 1, 3'd2, 32'h000D0804, 4'd6, "R7 example edx disp32"));
    for (int r = 0; r < 8; r++) begin
      logic [7:0] m;
      m = 8'hC0 | 8'(r << 3) | 8'(7 - r);
      sendSeq(2, {8'hDC, m, 32'h0}, mk(3'(r), 0, 0, 3'(7 - r), 32'd0, 4'd2, "R4 R5 register form op sweep"));
    end
    sendSeq(3, {24'hDC_41_7F, 24'h0}, mk(3'd0, 1, 1, 3'd1, 32'h0000007F, 4'd3, "R8 disp8 positive"));
    sendSeq(3, {24'hDC_75_80, 24'h0}, mk(3'd6, 1, 1, 3'd5, 32'hFFFFFF80, 4'd3, "R8 disp8 negative ebp base"));
    sendSeq(2, {16'hDC_23, 32'h0}, mk(3'd4, 1, 1, 3'd3, 32'd0, 4'd2, "R9 mod0 no disp"));
    sendSeq(2, {16'hDC_38, 32'h0}, mk(3'd7, 1, 1, 3'd0, 32'd0, 4'd2, "R9 R6 mod0 rm0"));
    sendSeq(6, 48'hDC_0D_78_56_34_12, mk(3'd1, 1, 0, 3'd5, 32'h12345678, 4'd6, "R10 absolute disp32"));
    sendSeq(1, {8'hD8, 40'h0}, mkErr(4'd1, "R3 foreign opcode"));
    sendSeq(2, {16'hDC_04, 32'h0}, mkErr(4'd2, "R11 sib mod0"));
    sendSeq(2, {16'hDC_44, 32'h0}, mkErr(4'd2, "R11 sib mod1"));
    sendSeq(2, {16'hDC_8C, 32'h0}, mkErr(4'd2, "R11 sib mod2"));
    sendSeq(6, 48'hDC_B7_FF_FF_FF_FF, mk(3'd6, 1, 1, 3'd7, 32'hFFFFFFFF, 4'd6, "R7 R2 after errors"));
    sendSeq(2, {16'hDC_C4, 32'h0}, mk(3'd0, 0, 0, 3'd4, 32'd0, 4'd2, "R5 rm4 register not sib"));

    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(outValid === 1'b0 && inReady === 1'b1, "R2 back to opcode wait",
          $sformatf("v=%b r=%b", outValid, inReady), "v=0 r=1");
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule